// File: doc/BRIEF.md
# LCD Refresh Scan Timing Generator

This block produces the refresh timing for a dot-matrix LCD. It runs continuously and walks display memory one line at a time. Each line starts at a base address. The first line of a frame uses the configured start address, and each later line adds the bytes-per-line count to the base. Every fetched byte is sent out as a run of serial dots, least significant bit first. Each dot is carried by one pulse of a shift clock. After the last dot of a line, a one-cycle line latch pulse follows. A frame marker stays high for the whole first line of each frame. The AC-drive signal flips once per frame, so the panel never sees a DC bias. In graphics use, the fetched bytes are the bitmap itself.

The configuration is sampled once, at the start of each frame. It sets the dots per byte (6 to 8), the bytes per line (an even count, 2 to 128) and the lines per frame (1 to 128). Changing the start address between frames moves the picture: adding the bytes-per-line count scrolls it by one row. When the display is disabled, the dot output is held low and every timing signal keeps running.

The control path is one state machine with these states:
- ST_START: latches the configuration and loads the frame base.
- ST_FETCH: drives the memory read.
- ST_LOAD: captures the byte.
- ST_DOT_LO: shift clock low.
- ST_DOT_HI: shift clock high.
- ST_LATCH: the line latch pulse.

The transitions are:
- START→FETCH.
- FETCH→LOAD.
- LOAD→DOT_LO.
- DOT_LO→DOT_HI.
- DOT_HI→DOT_LO when more dots remain in the byte.
- DOT_HI→FETCH on the last dot when more bytes remain in the line.
- DOT_HI→LATCH on the last dot of the last byte.
- LATCH→FETCH when more lines remain, moving to the next line.
- LATCH→START after the last line, which also flips the AC drive.

A line therefore takes HN·(2+2·HP)+1 cycles, and each frame adds one ST_START cycle.

Top module: `lcd_scan_timer`

## Requirements
- R1: While rst_n is low, shift_clk, line_latch, vram_rd, dot_d and ac_drive are 0, and frame_mark is 1.
- R2: Each fetched byte gives exactly HP = cfg_pitch_m1+1 shift_clk pulses. Each pulse is one cycle high, preceded by one cycle low. During pulse k (k = 0 first), dot_d equals bit k of the byte, so the least significant bit comes first, and dot_d is the same value in the low cycle before the pulse.
- R3: Each line fetches HN = cfg_bytes_m1+1 bytes. After the last dot of the line comes a single one-cycle line_latch pulse, during which shift_clk and vram_rd are 0.
- R4: Line L of a frame (L = 0 first) fetches byte b from address (S + L·HN + b) mod 2^16, where S is the frame's start address. A frame has NX = cfg_lines_m1+1 lines, and the next frame starts again at line 0.
- R5: frame_mark is 1 for every fetch and at the latch of line 0, and 0 at those points on every other line.
- R6: ac_drive is 0 after reset and changes exactly once per frame, in the cycle after the latch of the frame's last line.
- R7: While disp_en is 0, dot_d stays 0, and shift_clk, line_latch, vram_rd and the address sequence run unchanged.
- R8: cfg_start, cfg_pitch_m1, cfg_bytes_m1 and cfg_lines_m1 are sampled only at the start of a frame. A change to cfg_start in the middle of a frame takes effect from the next frame.
- R9: vram_rd is a one-cycle strobe. vram_addr holds its value in the following cycle, and vram_rdata is captured in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_en | input | 1 | Display enable; 0 blanks the dot output |
| cfg_pitch_m1 | input | 3 | Dots per byte minus one (5 to 7) |
| cfg_bytes_m1 | input | 7 | Bytes per line minus one (odd value, so the count is even) |
| cfg_lines_m1 | input | 7 | Lines per frame minus one |
| cfg_start | input | 16 | Memory address of the top-left byte |
| vram_rdata | input | 8 | Memory read data, valid the cycle after vram_rd |
| vram_addr | output | 16 | Memory fetch address |
| vram_rd | output | 1 | Fetch strobe |
| dot_d | output | 1 | Serial dot data |
| shift_clk | output | 1 | Dot shift clock |
| line_latch | output | 1 | Line latch pulse |
| frame_mark | output | 1 | High during the first line of a frame |
| ac_drive | output | 1 | AC-drive polarity, toggles per frame |

## Verification
The assertions take for granted that cfg_pitch_m1 is in the range 5 to 7 and that the memory answers combinationally or in the cycle after the strobe. They also assume that disp_en only moves between a low and a high shift-clock phase when the hold check is waived. The bench applies each configuration under reset and keeps disp_en constant within a run. The only configuration field it changes mid-frame is the start address, which is meant to take effect at the next frame. The bench memory is a combinational function of the address, so read data always follows the held address.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [2:0] {
        ST_START  = 3'd0,
        ST_FETCH  = 3'd1,
        ST_LOAD   = 3'd2,
        ST_DOT_LO = 3'd3,
        ST_DOT_HI = 3'd4,
        ST_LATCH  = 3'd5
    } scan_state_t;

endpackage

// File: rtl/lcd_dot_shifter.sv
module lcd_dot_shifter #(
    parameter int BYTE_W  = 8,
    parameter int PITCH_W = $clog2(BYTE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [PITCH_W-1:0] pitch_m1,
    input  logic [BYTE_W-1:0]  din,
    output logic               dot,
    output logic               last_dot
);

    logic [BYTE_W-1:0]  sh_q;
    logic [PITCH_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= din;
            cnt_q <= '0;
        end else if (step) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + PITCH_W'(1);
        end
    end

    assign dot      = sh_q[0];
    assign last_dot = (cnt_q == pitch_m1);

    AST_DOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= pitch_m1); // R2

endmodule

// File: rtl/lcd_line_walker.sv
module lcd_line_walker #(
    parameter int ADDR_W  = 16,
    parameter int COUNT_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               byte_next,
    input  logic               line_next,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [COUNT_W-1:0] bytes_m1,
    input  logic [COUNT_W-1:0] lines_m1,
    output logic [ADDR_W-1:0]  addr,
    output logic               last_byte,
    output logic               last_line,
    output logic               first_line
);

    localparam int PAD_W = ADDR_W - COUNT_W;

    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [COUNT_W-1:0] byte_q;
    logic [COUNT_W-1:0] line_q;
    logic [ADDR_W-1:0]  stride;
    logic [ADDR_W-1:0]  next_base;

    assign stride    = {{PAD_W{1'b0}}, bytes_m1} + ADDR_W'(1);
    assign next_base = base_q + stride;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            addr_q <= '0;
            byte_q <= '0;
            line_q <= '0;
        end else if (frame_start) begin
            base_q <= start_addr;
            addr_q <= start_addr;
            byte_q <= '0;
            line_q <= '0;
        end else if (line_next) begin
            base_q <= next_base;
            addr_q <= next_base;
            byte_q <= '0;
            line_q <= line_q + COUNT_W'(1);
        end else if (byte_next) begin
            addr_q <= addr_q + ADDR_W'(1);
            byte_q <= byte_q + COUNT_W'(1);
        end
    end

    assign addr       = addr_q;
    assign last_byte  = (byte_q == bytes_m1);
    assign last_line  = (line_q == lines_m1);
    assign first_line = (line_q == '0);

    AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        byte_q <= bytes_m1); // R3
    AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        line_q <= lines_m1); // R4

endmodule

// File: rtl/lcd_ac_drive.sv
module lcd_ac_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic m
);

    logic m_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= 1'b0;
        else if (flip) m_q <= ~m_q;
    end

    assign m = m_q;

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
    parameter int ADDR_W  = 16,
    parameter int BYTE_W  = 8,
    parameter int COUNT_W = 7,
    parameter int PITCH_W = $clog2(BYTE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               disp_en,
    input  logic [PITCH_W-1:0] cfg_pitch_m1,
    input  logic [COUNT_W-1:0] cfg_bytes_m1,
    input  logic [COUNT_W-1:0] cfg_lines_m1,
    input  logic [ADDR_W-1:0]  cfg_start,
    input  logic [BYTE_W-1:0]  vram_rdata,
    output logic [ADDR_W-1:0]  vram_addr,
    output logic               vram_rd,
    output logic               dot_d,
    output logic               shift_clk,
    output logic               line_latch,
    output logic               frame_mark,
    output logic               ac_drive
);

    import lcd_scan_pkg::*;

    scan_state_t state_q, state_d;

    logic [PITCH_W-1:0] pitch_q;
    logic [COUNT_W-1:0] bytes_q;
    logic [COUNT_W-1:0] lines_q;

    logic ld_byte, step_dot, frame_start, byte_next, line_next, m_flip;
    logic dot_raw, last_dot, last_byte, last_line, first_line;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_START;
        else        state_q <= state_d;
    end

    // configuration is sampled once per frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pitch_q <= PITCH_W'(BYTE_W - 1);
            bytes_q <= COUNT_W'(1);
            lines_q <= '0;
        end else if (state_q == ST_START) begin
            pitch_q <= cfg_pitch_m1;
            bytes_q <= cfg_bytes_m1;
            lines_q <= cfg_lines_m1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START:  state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_DOT_LO;
            ST_DOT_LO: state_d = ST_DOT_HI;
            ST_DOT_HI: begin
                if (!last_dot)       state_d = ST_DOT_LO;
                else if (!last_byte) state_d = ST_FETCH;
                else                 state_d = ST_LATCH;
            end
            ST_LATCH:  state_d = last_line ? ST_START : ST_FETCH;
            default:   state_d = ST_START;
        endcase
    end

    // outputs and strobes
    always_comb begin
        vram_rd     = 1'b0;
        shift_clk   = 1'b0;
        line_latch  = 1'b0;
        dot_d       = 1'b0;
        ld_byte     = 1'b0;
        step_dot    = 1'b0;
        frame_start = 1'b0;
        byte_next   = 1'b0;
        line_next   = 1'b0;
        m_flip      = 1'b0;
        unique case (state_q)
            ST_START: begin
                frame_start = 1'b1;
                ld_byte     = 1'b1;
            end
            ST_FETCH:  vram_rd = 1'b1;
            ST_LOAD:   ld_byte = 1'b1;
            ST_DOT_LO: dot_d   = disp_en & dot_raw;
            ST_DOT_HI: begin
                shift_clk = 1'b1;
                dot_d     = disp_en & dot_raw;
                step_dot  = !last_dot;
                byte_next = last_dot && !last_byte;
            end
            ST_LATCH: begin
                line_latch = 1'b1;
                line_next  = !last_line;
                m_flip     = last_line;
            end
            default: ;
        endcase
    end

    lcd_dot_shifter #(.BYTE_W(BYTE_W), .PITCH_W(PITCH_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_byte),
        .step     (step_dot),
        .pitch_m1 (pitch_q),
        .din      (vram_rdata),
        .dot      (dot_raw),
        .last_dot (last_dot)
    );

    lcd_line_walker #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .byte_next   (byte_next),
        .line_next   (line_next),
        .start_addr  (cfg_start),
        .bytes_m1    (bytes_q),
        .lines_m1    (lines_q),
        .addr        (vram_addr),
        .last_byte   (last_byte),
        .last_line   (last_line),
        .first_line  (first_line)
    );

    lcd_ac_drive u_ac (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (m_flip),
        .m     (ac_drive)
    );

    assign frame_mark = first_line;

    AST_CL2_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_clk |=> !shift_clk); // R2
    AST_CL2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(shift_clk) && $stable(disp_en)) |-> $stable(dot_d)); // R2
    AST_LATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_latch |=> !line_latch && !shift_clk); // R3
    AST_M_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_drive != $past(ac_drive)) |-> $past(line_latch)); // R6
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        vram_rd |=> $stable(vram_addr) && !vram_rd); // R9

endmodule

// File: tb/sim_lcd_scan_timer.sv
module sim_lcd_scan_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_en = 1'b1;
    logic [2:0]  cfg_pitch_m1 = 3'd7;
    logic [6:0]  cfg_bytes_m1 = 7'd1;
    logic [6:0]  cfg_lines_m1 = 7'd0;
    logic [15:0] cfg_start = 16'h0000;
    logic [7:0]  vram_rdata;
    logic [15:0] vram_addr;
    logic        vram_rd, dot_d, shift_clk, line_latch, frame_mark, ac_drive;

    always #4 clk = ~clk;

    function automatic logic [7:0] vmem(input logic [15:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
    endfunction

    assign vram_rdata = vmem(vram_addr);

    lcd_scan_timer u0 (
        .clk(clk), .rst_n(rst_n), .disp_en(disp_en),
        .cfg_pitch_m1(cfg_pitch_m1), .cfg_bytes_m1(cfg_bytes_m1),
        .cfg_lines_m1(cfg_lines_m1), .cfg_start(cfg_start),
        .vram_rdata(vram_rdata), .vram_addr(vram_addr), .vram_rd(vram_rd),
        .dot_d(dot_d), .shift_clk(shift_clk), .line_latch(line_latch),
        .frame_mark(frame_mark), .ac_drive(ac_drive)
    );

    int t_checks = 0, t_fails = 0, m_checks = 0, m_fails = 0;
    int t_hp = 8, t_hn = 2, t_nx = 1;
    logic mon_on = 1'b0;
    logic [15:0] pend_start = 16'h0;

    // monitor model state
    int L, b, k, dots, frames_done;
    logic [7:0]  cur_byte;
    logic [15:0] cur_start, prev_addr, exp_addr;
    logic prev_rd, m_exp, exp_dot;

    task automatic mchk(input bit ok, input string tag, input int act, input int exp);
        m_checks++;
        if (!ok) begin
            m_fails++;
            $display("FAIL %s actual=%0h expected=%0h (line %0d byte %0d)", tag, act, exp, L, b);
        end
    endtask

    task automatic tchk(input bit ok, input string tag, input int act, input int exp);
        t_checks++;
        if (!ok) begin
            t_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            L = 0; b = 0; k = 0; dots = 0; frames_done = 0;
            cur_byte = '0; cur_start = cfg_start; prev_rd = 1'b0;
            prev_addr = '0; m_exp = 1'b0;
        end else if (mon_on) begin
            if (prev_rd) mchk(vram_addr == prev_addr, "R9 addr hold", vram_addr, prev_addr);
            prev_rd = vram_rd;
            prev_addr = vram_addr;
            if (vram_rd) begin
                exp_addr = cur_start + 16'(L * t_hn + b);
                mchk(vram_addr == exp_addr, "R4 fetch addr", vram_addr, exp_addr);
                mchk(frame_mark == (L == 0), "R5 frame_mark at fetch", frame_mark, L == 0);
                if (L == 0 && b == 0)
                    mchk(ac_drive == m_exp, "R6 ac_drive at frame", ac_drive, m_exp);
                cur_byte = vmem(exp_addr);
                b++;
                k = 0;
            end
            if (shift_clk) begin
                exp_dot = disp_en ? cur_byte[k] : 1'b0;
                mchk(dot_d == exp_dot, disp_en ? "R2 dot" : "R7 dark dot", dot_d, exp_dot);
                k++;
                dots++;
            end
            if (line_latch) begin
                mchk(b == t_hn, "R3 bytes per line", b, t_hn);
                mchk(dots == t_hn * t_hp, "R2 dots per line", dots, t_hn * t_hp);
                mchk(frame_mark == (L == 0), "R5 frame_mark at latch", frame_mark, L == 0);
                mchk(!shift_clk && !vram_rd, "R3 latch isolated", {shift_clk, vram_rd}, 0);
                b = 0;
                dots = 0;
                if (L == t_nx - 1) begin
                    L = 0;
                    frames_done++;
                    cur_start = pend_start;
                    m_exp = !ac_drive;
                end else begin
                    L++;
                end
            end
        end
    end

    task automatic run_cfg(input int hp, input int hn, input int nx, input logic [15:0] st,
                           input logic en, input int nframes,
                           input bit change, input logic [15:0] st2);
        int fails_before;
        mon_on = 1'b0;
        rst_n = 1'b0;
        t_hp = hp; t_hn = hn; t_nx = nx;
        cfg_pitch_m1 = 3'(hp - 1);
        cfg_bytes_m1 = 7'(hn - 1);
        cfg_lines_m1 = 7'(nx - 1);
        cfg_start = st;
        pend_start = st;
        disp_en = en;
        repeat (3) @(negedge clk);
        // R1 reset state
        tchk({shift_clk, line_latch, vram_rd, dot_d, ac_drive} == 5'b0, "R1 reset outputs",
             {shift_clk, line_latch, vram_rd, dot_d, ac_drive}, 0);
        tchk(frame_mark == 1'b1, "R1 reset frame_mark", frame_mark, 1);
        fails_before = m_fails;
        mon_on = 1'b1;
        rst_n = 1'b1;
        if (change) begin
            while (L != 1) @(negedge clk);
            cfg_start = st2;
            pend_start = st2;
        end
        while (frames_done < nframes) @(negedge clk);
        if (change)
            tchk(m_fails == fails_before, "R8 start change deferred", m_fails - fails_before, 0);
        if (!en)
            tchk(m_fails == fails_before, "R7 timing while dark", m_fails - fails_before, 0);
        mon_on = 1'b0;
    endtask

    initial begin
        // near-exhaustive sweep of small configurations (R2 R3 R4 R5 R6)
        for (int hp = 6; hp <= 8; hp++)
            for (int hn = 2; hn <= 6; hn += 2)
                for (int nx = 1; nx <= 3; nx++)
                    run_cfg(hp, hn, nx,
                            (hp == 7) ? 16'hFFFB : 16'(16'h0100 * hn + nx),
                            1'b1, 2, 1'b0, 16'h0);
        // boundary counts
        run_cfg(6, 128, 2, 16'hFF80, 1'b1, 2, 1'b0, 16'h0);   // R3 widest line, R4 wrap
        run_cfg(8, 2, 128, 16'h1234, 1'b1, 2, 1'b0, 16'h0);   // R4 tallest frame
        // display disabled: timing continues, dots dark (R7)
        run_cfg(7, 4, 3, 16'h0040, 1'b0, 2, 1'b0, 16'h0);
        // scroll by one row between frames, set mid-frame (R8)
        run_cfg(8, 4, 3, 16'h0200, 1'b1, 2, 1'b1, 16'h0204);
        run_cfg(6, 2, 2, 16'h0010, 1'b1, 3, 1'b1, 16'hFFFF);
        $display("TB_RESULT checks=%0d failures=%0d", t_checks + m_checks, t_fails + m_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", t_checks + m_checks + 1, t_fails + m_fails + 1);
        $finish;
    end

endmodule